// File: doc/BRIEF.md
# Dual-Command Latching Memory Cell

This block is a single-bit set/clear storage element steered by two maintained, active-high command levels: a set command and a clear command. It drives a standard output and a complementary output that is always its inverse. Commands are arbitrated by ownership. The first command to be asserted owns the cell for as long as it stays asserted, and the other command is locked out during that time. When the owner is released, a command that is still held takes over on the next clock edge. When both commands appear together while the cell has no owner, the clear command wins.

After power returns, which is modelled by releasing an asynchronous active-low power-good reset, a start-up sequencer holds the cell in an initialisation window for `INIT_CYCLES` clock edges. Commands are ignored during this window. A mode input selects what the cell holds during the window. In off-return mode the cell is forced clear. In retentive mode it reloads a retention register. That register has no reset, so it survives a power loss, and it copies the live next state on every clock edge outside the initialisation window.

Top module: `dual_cmd_memory`

## Requirements
- R1: With `retain_mode` = 0 (off-return), `q_std` is 0 and `q_cmp` is 1 on every edge of the initialisation window and afterwards, until a set command is honoured.
- R2: Outside initialisation, a set command (`cmd_set` = 1) issued with no clear owner makes `q_std` 1 after the next rising edge, and `q_std` stays 1 after the set command is released.
- R3: Outside initialisation, a clear command (`cmd_clr` = 1) issued with no set owner makes `q_std` 0 after the next rising edge.
- R4: While the owning command stays asserted, asserting the opposing command leaves `q_std` unchanged.
- R5: If the owning command is released while the opposing command is held, the held command takes effect at that same sampling edge.
- R6: If both commands are sampled asserted while the cell has no owner, the clear command wins and `q_std` becomes 0.
- R7: `q_cmp` is always the bitwise inverse of `q_std`.
- R8: For `INIT_CYCLES` rising edges after `pwr_ok_n` is released, command inputs have no effect on the outputs.
- R9: With `retain_mode` = 1 (retentive), the output during and after initialisation equals the `q_std` value held when power was lost.
- R10: On every rising edge outside initialisation, the retention register loads the new live state, so it matches `q_std` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok_n | input | 1 | Asynchronous active-low power-good; low models loss of power |
| retain_mode | input | 1 | 0 = off-return power-up, 1 = retentive power-up |
| cmd_set | input | 1 | Maintained set (ON) command, active high |
| cmd_clr | input | 1 | Maintained clear (OFF) command, active high |
| q_std | output | 1 | Standard output |
| q_cmp | output | 1 | Complementary output |

## Verification
The ownership arbiter has two decisions that can land on the same edge. In one, the owning command is released while the opposing command is still held, so ownership hands over. In the other, both commands rise together on an unowned cell, and the clear-priority rule decides. The stimulus table drives both commands asserted from each of the three ownership states (set owner, clear owner, no owner), and also drives a release of one command with the other held. Each vector has its expected output, which is compared one edge later. Power cycles in both modes then check that commands toggling inside the initialisation window are overridden by the forced or restored value.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_SET  = 2'd1,
        OWN_CLR  = 2'd2
    } owner_e;

    typedef struct packed {
        logic   state;
        owner_e owner;
    } cell_s;

endpackage

// File: rtl/dmc_powerup_seq.sv
module dmc_powerup_seq #(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic pwr_ok_n,
    output logic in_init
);
    localparam int CW = $clog2(INIT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LOAD = CW'(INIT_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge pwr_ok_n) begin
        if (!pwr_ok_n) begin
            cnt_q <= CNT_LOAD;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign in_init = (cnt_q != '0);

endmodule

// File: rtl/dmc_arbiter.sv
module dmc_arbiter
    import dmc_pkg::*;
(
    input  logic   cmd_set,
    input  logic   cmd_clr,
    input  cell_s  cur,
    output cell_s  nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur.owner)
            OWN_SET: begin
                if (!cmd_set) begin
                    if (cmd_clr) begin
                        nxt.owner = OWN_CLR;
                        nxt.state = 1'b0;
                    end else begin
                        nxt.owner = OWN_NONE;
                    end
                end
            end
            OWN_CLR: begin
                if (!cmd_clr) begin
                    if (cmd_set) begin
                        nxt.owner = OWN_SET;
                        nxt.state = 1'b1;
                    end else begin
                        nxt.owner = OWN_NONE;
                    end
                end
            end
            default: begin
                if (cmd_clr) begin
                    nxt.owner = OWN_CLR;
                    nxt.state = 1'b0;
                end else if (cmd_set) begin
                    nxt.owner = OWN_SET;
                    nxt.state = 1'b1;
                end else begin
                    nxt.owner = OWN_NONE;
                end
            end
        endcase
    end

endmodule

// File: rtl/dmc_retain.sv
module dmc_retain (
    input  logic clk,
    input  logic load_en,
    input  logic state_in,
    output logic ret_q
);
    logic ret_d;

    always_comb begin
        ret_d = ret_q;
        if (load_en) begin
            ret_d = state_in;
        end
    end

    always_ff @(posedge clk) begin
        ret_q <= ret_d;
    end

endmodule

// File: rtl/dual_cmd_memory.sv
module dual_cmd_memory
    import dmc_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic clk,
    input  logic pwr_ok_n,
    input  logic retain_mode,
    input  logic cmd_set,
    input  logic cmd_clr,
    output logic q_std,
    output logic q_cmp
);
    localparam int INIT_EFF = (INIT_CYCLES < 1) ? 1 : INIT_CYCLES;

    logic  in_init;
    logic  ret_q;
    cell_s cell_d, cell_q, arb_nxt;

    dmc_powerup_seq #(.INIT_CYCLES(INIT_EFF)) u_seq (
        .clk      (clk),
        .pwr_ok_n (pwr_ok_n),
        .in_init  (in_init)
    );

    dmc_arbiter u_arb (
        .cmd_set (cmd_set),
        .cmd_clr (cmd_clr),
        .cur     (cell_q),
        .nxt     (arb_nxt)
    );

    dmc_retain u_ret (
        .clk      (clk),
        .load_en  (!in_init),
        .state_in (cell_d.state),
        .ret_q    (ret_q)
    );

    always_comb begin
        cell_d = arb_nxt;
        if (in_init) begin
            cell_d.owner = OWN_NONE;
            cell_d.state = retain_mode ? ret_q : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge pwr_ok_n) begin
        if (!pwr_ok_n) begin
            cell_q <= '{state: 1'b0, owner: OWN_NONE};
        end else begin
            cell_q <= cell_d;
        end
    end

    assign q_std = cell_q.state;
    assign q_cmp = ~cell_q.state;

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker
    import dmc_pkg::*;
(
    input logic   clk,
    input logic   pwr_ok_n,
    input logic   retain_mode,
    input logic   cmd_set,
    input logic   cmd_clr,
    input logic   in_init,
    input logic   ret_q,
    input owner_e owner_q,
    input logic   q_std,
    input logic   q_cmp
);
    // R7
    a_r7_complement: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        q_cmp == !q_std);

    // R1 / R8: off-return init forces clear regardless of commands
    a_r1_offreturn_init: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        (in_init && !retain_mode) |=> !q_std);

    // R9: retentive init restores stored value
    a_r9_restore: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        (in_init && retain_mode && $past(in_init)) |=> q_std == $past(ret_q));

    // R2
    a_r2_set: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        (!in_init && cmd_set && !cmd_clr && owner_q != OWN_CLR) |=> q_std);

    // R3
    a_r3_clear: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        (!in_init && cmd_clr && owner_q != OWN_SET) |=> !q_std);

    // R4
    a_r4_lockout: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        (!in_init && owner_q == OWN_SET && cmd_set) |=> q_std);

    // R10
    a_r10_follow: assert property (@(posedge clk) disable iff (!pwr_ok_n)
        !in_init |=> ret_q == q_std);

endmodule

bind dual_cmd_memory dmc_checker u_chk (
    .clk         (clk),
    .pwr_ok_n    (pwr_ok_n),
    .retain_mode (retain_mode),
    .cmd_set     (cmd_set),
    .cmd_clr     (cmd_clr),
    .in_init     (in_init),
    .ret_q       (ret_q),
    .owner_q     (cell_q.owner),
    .q_std       (q_std),
    .q_cmp       (q_cmp)
);

// File: tb/sim_dual_cmd_memory.sv
module sim_dual_cmd_memory;
    localparam int INIT_N = 5;
    localparam int NVEC   = 12;
    // {cmd_set, cmd_clr, expected q_std}
    localparam logic [2:0] VEC [NVEC] = '{
        3'b101, // R2 set from idle
        3'b111, // R4 clear ignored while set owns
        3'b010, // R5 set released, held clear takes over
        3'b110, // R4 set ignored while clear owns
        3'b000, // R3 stays clear
        3'b101, // R2 set
        3'b001, // R2 held after release
        3'b110, // R6 both together from idle: clear wins
        3'b101, // R5 clear released, held set takes over
        3'b001, // R2 hold
        3'b010, // R3 clear
        3'b101  // R2 set, leaves cell at 1
    };

    logic clk = 1'b0;
    logic pwr_ok_n = 1'b0;
    logic retain_mode = 1'b0;
    logic cmd_set = 1'b0;
    logic cmd_clr = 1'b0;
    logic q_std, q_cmp;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    dual_cmd_memory #(.INIT_CYCLES(INIT_N)) u0 (
        .clk(clk), .pwr_ok_n(pwr_ok_n), .retain_mode(retain_mode),
        .cmd_set(cmd_set), .cmd_clr(cmd_clr), .q_std(q_std), .q_cmp(q_cmp)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (q_std !== exp) begin
            n_fail++;
            $display("FAIL %s: q_std=%b expected %b", req, q_std, exp);
        end
        n_chk++;
        if (q_cmp !== ~exp) begin
            n_fail++;
            $display("FAIL R7 (%s): q_cmp=%b expected %b", req, q_cmp, ~exp);
        end
    endtask

    task automatic step(input logic s, input logic c, input logic exp, input string req);
        cmd_set = s;
        cmd_clr = c;
        @(posedge clk);
        @(negedge clk);
        chk(req, exp);
    endtask

    // power loss then power return in the given mode; commands toggle during init
    task automatic power_cycle(input logic mode, input logic exp, input string req);
        @(negedge clk);
        pwr_ok_n = 1'b0;
        cmd_set = 1'b0;
        cmd_clr = 1'b0;
        repeat (2) @(negedge clk);
        retain_mode = mode;
        pwr_ok_n = 1'b1;
        for (int i = 0; i < INIT_N; i++) begin
            cmd_set = i[0];
            cmd_clr = ~i[0];
            @(posedge clk);
            @(negedge clk);
            chk({req, " R8 init"}, exp);
        end
        step(1'b0, 1'b0, exp, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0);
        pwr_ok_n = 1'b1;
        for (int i = 0; i < INIT_N; i++) begin
            cmd_set = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk("R1 R8 off-return init", 1'b0);
        end
        step(1'b0, 1'b0, 1'b0, "R1 after init");
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R2-6 vector %0d", i));
        end
        power_cycle(1'b1, 1'b1, "R9 R10 restore set");
        step(1'b0, 1'b1, 1'b0, "R3 clear after restore");
        step(1'b0, 1'b0, 1'b0, "R3 hold clear");
        power_cycle(1'b1, 1'b0, "R9 R10 restore clear");
        step(1'b1, 1'b0, 1'b1, "R2 set before off-return cycle");
        power_cycle(1'b0, 1'b0, "R1 off-return forced clear");
        step(1'b1, 1'b1, 1'b0, "R6 simultaneous after power-up");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule